// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It splits the address into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. When paging is on and the small translation cache misses, the walker reads one directory entry, located from the directory base register. It then reads one table entry from the frame that the directory entry names. The physical address is the table entry's frame number joined to the page offset.

Each level is checked for the present, writable and user bits. An access that fails a check returns a fault carrying the linear address and a cause code. When paging is off, the address passes through unchanged. The cache holds four completed translations. Every write to the base register empties it.

A client hands over one request at a time and receives exactly one response pulse for it. Entries are 32-bit words: the frame number is in bits [31:12], present is bit 0, writable is bit 1 and user is bit 2.

Top module: `ptw_walker`

## Requirements
- R1: With `pg_en` low, an accepted request is answered in the next cycle with `resp_addr` equal to the request address, `resp_fault` low, and no memory read.
- R2: A cache miss with `pg_en` high reads the directory entry first, at {base[31:12], addr[31:22], 2'b00}. It then reads the table entry, at {dir_entry[31:12], addr[21:12], 2'b00}, and answers {tbl_entry[31:12], addr[11:0]}.
- R3: An entry with bit 0 clear faults as not-present. The cause is 3'b001 at the directory level, and in that case no table read is made. At the table level the cause is 3'b101. On every fault `resp_addr` carries the linear address.
- R4: A user access (`req_user` high) to an entry with bit 2 clear faults with cause 3'b010 at the directory level or 3'b110 at the table level.
- R5: A write to an entry with bit 1 clear faults with cause 3'b011 at the directory level or 3'b111 at the table level. Within one level, not-present wins over user, and user wins over write. A directory fault wins over any table fault.
- R6: A walk that completes without a fault fills the cache. A later request to the same addr[31:12] is answered in the next cycle with no memory read. Its fault and cause are the same as a fresh walk would give.
- R7: The cache holds 4 translations and replaces them round-robin in fill order. A fifth distinct page evicts the oldest fill.
- R8: A base-register write empties the cache, so the next request to a cached page walks again. `req_ready` is low in the cycle of the write.
- R9: A base write that lands while a walk is in progress does not redirect that walk. The walk finishes with the old base, and its result is not cached.
- R10: `req_ready` is high after reset and whenever the walker is idle. It stays low while a walk is in progress. No response appears while a memory read is in progress.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_en | input | 1 | Paging enable; when low, addresses pass through |
| base_we | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | New directory base; bits [31:12] are kept |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Entry word returned by memory |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Response is a page fault |
| resp_cause | output | 3 | {level, kind}: kind 1 not present, 2 user, 3 write |
| resp_addr | output | 32 | Physical address, or the linear address on a fault |

## Verification
Some properties are checked by assertions on every cycle:
- the memory read stays stable until it is acknowledged;
- the walker does not accept a request or respond while a read is in progress;
- pass-through and cache hits answer one cycle after acceptance, with a hit making no read;
- a missing directory entry always gives cause 001;
- a fully permitted table entry gives a correct offset.

Other behaviour only the bench's scenarios can show:
- the exact pair of entry addresses read during a walk;
- cause priority across levels;
- round-robin eviction order;
- flush on a base write;
- a walk that outlives a base change keeping the old base and not caching its result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   // bit positions inside a directory or table entry word
   localparam int BIT_P = 0;
   localparam int BIT_W = 1;
   localparam int BIT_U = 2;

   // bit positions inside a cached two-bit permission field
   localparam int PERM_WR  = 0;
   localparam int PERM_USR = 1;

   typedef enum logic [1:0] {
      KIND_OK     = 2'd0,
      KIND_ABSENT = 2'd1,
      KIND_USER   = 2'd2,
      KIND_WRITE  = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIR  = 2'd1,
      ST_TBL  = 2'd2
   } state_e;
endpackage

// File: rtl/ptw_level_check.sv
module ptw_level_check
   import ptw_pkg::*;
(
   input  logic  present,
   input  logic  wr_ok,
   input  logic  user_ok,
   input  logic  acc_write,
   input  logic  acc_user,
   output kind_e kind
);
   // priority inside one level: absent, then user, then write
   always_comb begin
      if (!present)                   kind = KIND_ABSENT;
      else if (acc_user && !user_ok)  kind = KIND_USER;
      else if (acc_write && !wr_ok)   kind = KIND_WRITE;
      else                            kind = KIND_OK;
   end
endmodule

// File: rtl/ptw_tlb.sv
module ptw_tlb #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic [1:0]       lk_dir_perm,
   output logic [1:0]       lk_tbl_perm,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic [1:0]       fill_dir_perm,
   input  logic [1:0]       fill_tbl_perm
);
   localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int DATA_W = PFN_W + 4;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("ptw_tlb: ENTRIES must be at least 2");
      end
   endgenerate

   logic [PTR_W-1:0]  ptr_q;
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] vld_v;
   logic [DATA_W-1:0] data_v [ENTRIES];
   logic [DATA_W-1:0] sel_data;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         logic              vld_q;
         logic [VPN_W-1:0]  vpn_q;
         logic [DATA_W-1:0] data_q;
         logic              sel;

         assign sel = fill_en && (ptr_q == PTR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               vpn_q  <= '0;
               data_q <= '0;
            end else if (flush) begin
               vld_q  <= 1'b0;
            end else if (sel) begin
               vld_q  <= 1'b1;
               vpn_q  <= fill_vpn;
               data_q <= {fill_pfn, fill_dir_perm, fill_tbl_perm};
            end
         end

         assign match[g]  = vld_q && (vpn_q == lk_vpn);
         assign vld_v[g]  = vld_q;
         assign data_v[g] = data_q;
      end
   endgenerate

   always_comb begin
      sel_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) sel_data = sel_data | data_v[i];
      end
   end

   assign lk_hit = |match;
   assign {lk_pfn, lk_dir_perm, lk_tbl_perm} = sel_data;

   // round-robin victim pointer, rewound on flush
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (flush)    ptr_q <= '0;
      else if (fill_en)  ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
   end

   // R7: fills happen only on misses, so one page never sits in two slots
   a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R8: a flush leaves no valid slot behind
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_v == '0));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int OFF_BITS    = 12,
   parameter int IDX_BITS    = 10,
   parameter int TLB_ENTRIES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pg_en,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_user,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              resp_valid,
   output logic              resp_fault,
   output logic [2:0]        resp_cause,
   output logic [ADDR_W-1:0] resp_addr
);
   localparam int VPN_W  = ADDR_W - OFF_BITS;
   localparam int PAD_W  = OFF_BITS - IDX_BITS;
   localparam int LEVELS = 2;

   generate
      if (VPN_W != LEVELS * IDX_BITS) begin : g_bad_split
         $error("ptw_walker: index fields must cover the page number");
      end
      if (PAD_W != 2) begin : g_bad_entry
         $error("ptw_walker: entries must be four bytes and fill one page");
      end
   endgenerate

   state_e            st_q;
   logic [VPN_W-1:0]  base_q;
   logic [VPN_W-1:0]  walk_base_q;
   logic [VPN_W-1:0]  tbl_frame_q;
   logic [ADDR_W-1:0] va_q;
   logic              wr_q;
   logic              usr_q;
   logic              stale_q;
   logic [1:0]        dir_perm_q;

   logic              accept;
   logic              tlb_hit;
   logic [VPN_W-1:0]  tlb_pfn;
   logic [1:0]        tlb_dir_perm;
   logic [1:0]        tlb_tbl_perm;
   logic              fill_en;
   logic [1:0]        hit_perm [LEVELS];
   kind_e             hit_kind [LEVELS];
   kind_e             walk_kind;
   logic [2:0]        hit_cause;
   logic              hit_fault;

   logic [IDX_BITS-1:0] dir_idx;
   logic [IDX_BITS-1:0] tbl_idx;

   assign dir_idx   = va_q[ADDR_W-1 -: IDX_BITS];
   assign tbl_idx   = va_q[OFF_BITS +: IDX_BITS];
   assign req_ready = (st_q == ST_IDLE) && !base_we;
   assign accept    = req_valid && req_ready;
   assign mem_req   = (st_q != ST_IDLE);
   assign mem_addr  = (st_q == ST_DIR) ? {walk_base_q, dir_idx, {PAD_W{1'b0}}}
                                       : {tbl_frame_q, tbl_idx, {PAD_W{1'b0}}};

   // a walk whose base changed underneath it must not be remembered
   assign fill_en = (st_q == ST_TBL) && mem_ack && (walk_kind == KIND_OK)
                    && !stale_q && !base_we;

   ptw_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (VPN_W)
   ) u_tlb (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (base_we),
      .lk_vpn        (req_addr[ADDR_W-1:OFF_BITS]),
      .lk_hit        (tlb_hit),
      .lk_pfn        (tlb_pfn),
      .lk_dir_perm   (tlb_dir_perm),
      .lk_tbl_perm   (tlb_tbl_perm),
      .fill_en       (fill_en),
      .fill_vpn      (va_q[ADDR_W-1:OFF_BITS]),
      .fill_pfn      (mem_rdata[ADDR_W-1:OFF_BITS]),
      .fill_dir_perm (dir_perm_q),
      .fill_tbl_perm ({mem_rdata[BIT_U], mem_rdata[BIT_W]})
   );

   assign hit_perm[0] = tlb_dir_perm;
   assign hit_perm[1] = tlb_tbl_perm;

   // cached pages were present at both levels; only rights are rechecked
   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_hit_chk
         ptw_level_check u_chk (
            .present   (1'b1),
            .wr_ok     (hit_perm[l][PERM_WR]),
            .user_ok   (hit_perm[l][PERM_USR]),
            .acc_write (req_write),
            .acc_user  (req_user),
            .kind      (hit_kind[l])
         );
      end
   endgenerate

   ptw_level_check u_walk_chk (
      .present   (mem_rdata[BIT_P]),
      .wr_ok     (mem_rdata[BIT_W]),
      .user_ok   (mem_rdata[BIT_U]),
      .acc_write (wr_q),
      .acc_user  (usr_q),
      .kind      (walk_kind)
   );

   always_comb begin
      if (hit_kind[0] != KIND_OK)      hit_cause = {1'b0, hit_kind[0]};
      else if (hit_kind[1] != KIND_OK) hit_cause = {1'b1, hit_kind[1]};
      else                             hit_cause = 3'b000;
   end
   assign hit_fault = (hit_cause[1:0] != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (base_we) begin
         base_q <= base_wdata[ADDR_W-1:OFF_BITS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         walk_base_q <= '0;
         tbl_frame_q <= '0;
         va_q        <= '0;
         wr_q        <= 1'b0;
         usr_q       <= 1'b0;
         stale_q     <= 1'b0;
         dir_perm_q  <= '0;
         resp_valid  <= 1'b0;
         resp_fault  <= 1'b0;
         resp_cause  <= '0;
         resp_addr   <= '0;
      end else begin
         resp_valid <= 1'b0;
         if (st_q != ST_IDLE && base_we) stale_q <= 1'b1;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  va_q        <= req_addr;
                  wr_q        <= req_write;
                  usr_q       <= req_user;
                  walk_base_q <= base_q;
                  stale_q     <= 1'b0;
                  if (!pg_en) begin
                     resp_valid <= 1'b1;
                     resp_fault <= 1'b0;
                     resp_cause <= 3'b000;
                     resp_addr  <= req_addr;
                  end else if (tlb_hit) begin
                     resp_valid <= 1'b1;
                     resp_fault <= hit_fault;
                     resp_cause <= hit_cause;
                     resp_addr  <= hit_fault ? req_addr
                                             : {tlb_pfn, req_addr[OFF_BITS-1:0]};
                  end else begin
                     st_q <= ST_DIR;
                  end
               end
            end
            ST_DIR: begin
               if (mem_ack) begin
                  if (walk_kind != KIND_OK) begin
                     resp_valid <= 1'b1;
                     resp_fault <= 1'b1;
                     resp_cause <= {1'b0, walk_kind};
                     resp_addr  <= va_q;
                     st_q       <= ST_IDLE;
                  end else begin
                     tbl_frame_q <= mem_rdata[ADDR_W-1:OFF_BITS];
                     dir_perm_q  <= {mem_rdata[BIT_U], mem_rdata[BIT_W]};
                     st_q        <= ST_TBL;
                  end
               end
            end
            ST_TBL: begin
               if (mem_ack) begin
                  resp_valid <= 1'b1;
                  st_q       <= ST_IDLE;
                  if (walk_kind != KIND_OK) begin
                     resp_fault <= 1'b1;
                     resp_cause <= {1'b1, walk_kind};
                     resp_addr  <= va_q;
                  end else begin
                     resp_fault <= 1'b0;
                     resp_cause <= 3'b000;
                     resp_addr  <= {mem_rdata[ADDR_W-1:OFF_BITS], va_q[OFF_BITS-1:0]};
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R11: an unacknowledged read keeps its address
   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R10: no acceptance and no response while a read is open
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (!req_ready && !resp_valid));

   // R1: pass-through answers next cycle with the same address
   a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !pg_en) |=> (resp_valid && !resp_fault && resp_addr == $past(req_addr)));

   // R6: a hit answers next cycle without touching memory
   a_r6_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pg_en && tlb_hit) |=> (resp_valid && !mem_req));

   // R3: a missing directory entry gives cause 001
   a_r3_dir_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DIR && mem_ack && !mem_rdata[BIT_P])
      |=> (resp_valid && resp_fault && resp_cause == 3'b001));

   // R2: a fully permitted table entry completes the walk with the offset kept
   a_r2_tbl_success: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TBL && mem_ack && mem_rdata[2:0] == 3'b111)
      |=> (resp_valid && !resp_fault
           && resp_addr[OFF_BITS-1:0] == $past(va_q[OFF_BITS-1:0])));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pg_en = 1'b0;
   logic        base_we = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        resp_valid;
   logic        resp_fault;
   logic [2:0]  resp_cause;
   logic [31:0] resp_addr;

   always #2.5 clk = ~clk;

   ptw_walker u_dut (
      .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .base_we(base_we),
      .base_wdata(base_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_fault(resp_fault),
      .resp_cause(resp_cause), .resp_addr(resp_addr)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit busy   = 0;

   // behavioural memory and reference model state
   logic [31:0] mem [logic [31:0]];
   int          lat = 1;
   int          mem_cnt = 0;
   int          reads = 0;
   logic [31:0] first_addr = '0;
   logic [31:0] rd_addrs [$];
   logic [31:0] m_base = '0;
   bit          m_vld [4];
   logic [19:0] m_vpn [4];
   logic [31:0] m_pde [4];
   logic [31:0] m_pte [4];
   int          m_ptr = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [1:0] kind_of(input logic [31:0] e, input bit w, input bit u);
      if (!e[0])      return 2'd1;
      if (u && !e[2]) return 2'd2;
      if (w && !e[1]) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [31:0] va_of(input int d, input int t, input int off);
      return {d[9:0], t[9:0], off[11:0]};
   endfunction

   // memory responder: acknowledges after lat cycles, then idles one cycle
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            mem_cnt = 0;
         end else if (mem_req) begin
            if (mem_cnt == 0) first_addr = mem_addr;
            mem_cnt++;
            if (mem_cnt >= lat) begin
               chk(mem_addr == first_addr, "R11", "read address held", mem_addr, first_addr);
               mem_ack   = 1'b1;
               mem_rdata = rd(mem_addr);
               rd_addrs.push_back(mem_addr);
               reads++;
            end
         end
      end
   end

   // no response may appear outside a request in flight
   initial begin
      forever begin
         @(posedge clk); #1;
         if (rst_n && resp_valid && !busy)
            chk(1'b0, "R10", "unexpected response", 32'h1, 32'h0);
      end
   end

   task automatic model_flush();
      for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
      m_ptr = 0;
   endtask

   task automatic set_base(input logic [31:0] nb);
      @(negedge clk);
      base_we = 1'b1; base_wdata = nb;
      req_valid = 1'b1; req_addr = 32'h00400000;
      #1;
      chk(req_ready == 1'b0, "R8", "ready during base write", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
      base_we = 1'b0; req_valid = 1'b0;
      m_base = nb;
      model_flush();
   endtask

   task automatic run_req(input logic [31:0] va, input bit w, input bit u,
                          input string tag, input bit mid_base = 1'b0,
                          input logic [31:0] nb = 32'h0);
      logic [31:0] pde, pte, a0, a1, eaddr;
      logic [31:0] ea [$];
      logic [1:0]  k0, k1;
      logic [2:0]  ec;
      int er, hi, cyc;
      bit fast, fill;
      pde = '0; pte = '0; k0 = 0; k1 = 0; ec = 0; er = 0; hi = -1;
      fast = 1'b0; fill = 1'b0; eaddr = va;
      if (!pg_en) begin
         fast = 1'b1;
      end else begin
         for (int i = 0; i < 4; i++)
            if (m_vld[i] && m_vpn[i] == va[31:12]) hi = i;
         if (hi >= 0) begin
            fast = 1'b1;
            k0 = kind_of(m_pde[hi], w, u);
            k1 = kind_of(m_pte[hi], w, u);
            if (k0 != 0)      ec = {1'b0, k0};
            else if (k1 != 0) ec = {1'b1, k1};
            eaddr = (ec != 0) ? va : {m_pte[hi][31:12], va[11:0]};
         end else begin
            a0 = {m_base[31:12], va[31:22], 2'b00};
            ea.push_back(a0);
            pde = rd(a0);
            er = 1;
            k0 = kind_of(pde, w, u);
            if (k0 != 0) begin
               ec = {1'b0, k0};
            end else begin
               a1 = {pde[31:12], va[21:12], 2'b00};
               ea.push_back(a1);
               pte = rd(a1);
               er = 2;
               k1 = kind_of(pte, w, u);
               if (k1 != 0) ec = {1'b1, k1};
               else begin
                  eaddr = {pte[31:12], va[11:0]};
                  fill  = !mid_base;
               end
            end
         end
      end
      rd_addrs.delete();
      reads = 0;
      @(negedge clk);
      busy = 1'b1;
      req_valid = 1'b1; req_addr = va; req_write = w; req_user = u;
      chk(req_ready == 1'b1, "R10", {tag, " ready when idle"}, {31'b0, req_ready}, 32'h1);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      if (mid_base) begin base_we = 1'b1; base_wdata = nb; end
      while (!resp_valid && cyc < 100) begin
         @(negedge clk);
         base_we = 1'b0;
         cyc++;
      end
      base_we = 1'b0;
      chk(resp_valid == 1'b1, tag, "response seen", {31'b0, resp_valid}, 32'h1);
      chk(resp_fault == (ec != 0), tag, "fault flag", {31'b0, resp_fault}, {31'b0, (ec != 0)});
      chk(resp_cause == ec, tag, "cause", {29'b0, resp_cause}, {29'b0, ec});
      chk(resp_addr == eaddr, tag, "address", resp_addr, eaddr);
      chk(reads == er, tag, "read count", reads, er);
      for (int i = 0; i < ea.size(); i++)
         if (i < rd_addrs.size())
            chk(rd_addrs[i] == ea[i], tag, "entry address", rd_addrs[i], ea[i]);
      if (fast) chk(cyc == 1, tag, "one-cycle latency", cyc, 1);
      busy = 1'b0;
      if (fill) begin
         m_vld[m_ptr] = 1'b1; m_vpn[m_ptr] = va[31:12];
         m_pde[m_ptr] = pde;  m_pte[m_ptr] = pte;
         m_ptr = (m_ptr + 1) % 4;
      end
      if (mid_base) begin
         m_base = nb;
         model_flush();
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         chk(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_flush();
      // directory at 0x10000, tables at 0x20000..0x23000
      mem[32'h00010004] = 32'h00020007;           // dir 1: U W P
      mem[32'h00010008] = 32'h00021003;           // dir 2: W P (kernel only)
      mem[32'h0001000C] = 32'h00022005;           // dir 3: U P (read only)
      mem[32'h00010010] = 32'h00023001;           // dir 4: P only
      mem[32'h0002000C] = 32'h00ABC007;           // dir1/tbl3
      mem[32'h00020014] = 32'h00AAA003;           // dir1/tbl5: kernel only
      mem[32'h00020018] = 32'h00BBB005;           // dir1/tbl6: read only
      mem[32'h00021000] = 32'h00777007;
      mem[32'h00022000] = 32'h00888007;
      mem[32'h00023000] = 32'h00999007;
      for (int i = 0; i < 5; i++)
         mem[32'h00020000 + (32'h10 + i) * 4] = {20'h00100 + 20'(i), 12'h007};
      // second directory at 0x30000
      mem[32'h00030004] = 32'h00040007;
      mem[32'h0004000C] = 32'h00DDD007;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready after reset", {31'b0, req_ready}, 32'h1);
      chk(resp_valid == 1'b0, "R10", "no response after reset", {31'b0, resp_valid}, 32'h0);
      chk(mem_req == 1'b0, "R11", "no read after reset", {31'b0, mem_req}, 32'h0);

      run_req(32'h12345678, 1'b1, 1'b1, "R1");
      set_base(32'h00010000);
      pg_en = 1'b1;

      run_req(va_of(1, 3, 12'h123), 1'b0, 1'b1, "R2");
      run_req(va_of(1, 3, 12'hFFC), 1'b1, 1'b1, "R6");
      lat = 3;
      run_req(va_of(5, 0, 12'h010), 1'b0, 1'b0, "R3");
      run_req(va_of(1, 4, 12'h020), 1'b0, 1'b0, "R3");
      run_req(va_of(2, 0, 12'h045), 1'b0, 1'b0, "R4");
      run_req(va_of(2, 0, 12'h046), 1'b0, 1'b1, "R4");
      run_req(va_of(1, 5, 12'h001), 1'b0, 1'b1, "R4");
      run_req(va_of(1, 5, 12'h002), 1'b1, 1'b0, "R2");
      lat = 1;
      run_req(va_of(3, 0, 12'h300), 1'b1, 1'b1, "R5");
      run_req(va_of(4, 0, 12'h400), 1'b1, 1'b1, "R5");
      run_req(va_of(4, 0, 12'h404), 1'b1, 1'b0, "R5");
      run_req(va_of(1, 6, 12'h600), 1'b1, 1'b1, "R5");
      run_req(va_of(1, 6, 12'h604), 1'b0, 1'b1, "R6");
      run_req(va_of(1, 6, 12'h608), 1'b1, 1'b1, "R6");

      set_base(32'h00010000);
      run_req(va_of(1, 3, 12'h123), 1'b0, 1'b1, "R8");

      set_base(32'h00010000);
      for (int i = 0; i < 5; i++) run_req(va_of(1, 16 + i, 12'h0A0), 1'b0, 1'b1, "R7");
      run_req(va_of(1, 17, 12'h0B0), 1'b0, 1'b1, "R7");
      run_req(va_of(1, 16, 12'h0C0), 1'b0, 1'b1, "R7");
      run_req(va_of(1, 18, 12'h0D0), 1'b0, 1'b1, "R7");

      lat = 2;
      run_req(va_of(1, 3, 12'h123), 1'b0, 1'b1, "R9", 1'b1, 32'h00030000);
      run_req(va_of(1, 3, 12'h124), 1'b0, 1'b1, "R9");
      run_req(va_of(1, 3, 12'h125), 1'b0, 1'b1, "R6");

      pg_en = 1'b0;
      run_req(va_of(1, 3, 12'h126), 1'b0, 1'b1, "R1");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule